// File: doc/BRIEF.md
# Fractional Scale-Step Baud Generator

This block derives a serial-line bit-rate enable from a fixed system clock. It has two stages. An integer prescaler divides the clock by (scale + 1). A 17-bit phase accumulator then adds a fractional step once per prescaler tick. Each time the accumulator wraps, the block emits a one-cycle baud tick.

The resulting mean rate is clk / (scale + 1) × step / 2^17. With scale 0 and step 603, a 25 MHz clock gives roughly 115 kbaud.

Scale and step arrive as two plain input fields. Any change in either field restarts both counters from zero, so the new rate starts from a clean phase. An enable input freezes the whole generator without losing its phase. Software decoding of the configuration word and the search for the best scale/step pair belong to other blocks.

Top module: `baud_phase_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `baud_tick` is 0. The prescaler count and the accumulator are both zero.
- R2: While enabled, the prescaler counts 0, 1, …, scale and then wraps to 0. It produces one internal tick per (scale + 1) enabled cycles.
- R3: After C enabled cycles from a cleared state, the number of baud ticks equals floor(floor(C / (scale + 1)) × step / 2^17). Here the accumulator is 17 bits wide and adds step once per prescaler tick.
- R4: `baud_tick` is registered. It goes high for exactly one cycle, in the cycle after the prescaler tick whose addition carries out of bit 16. With scale 0 and step 0x3333, the first tick is seen after the 11th enabled clock edge.
- R5: A step value above 0x3333 acts exactly as 0x3333.
- R6: Scale 0xFF is usable and divides by 256. With step 0x3333, the first tick is seen after enabled edge 2816.
- R7: Step 0 produces no baud ticks.
- R8: A change of scale or step, seen on a clock edge, clears the prescaler and the accumulator at that edge. No tick comes out of that edge, and counting restarts from zero on the next edge.
- R9: While `en` is low, no baud ticks appear and both counters hold. When `en` returns high, the sequence continues as if the pause had not happened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low freezes the generator |
| scale_i | input | 8 | Integer prescale value; divide by scale_i + 1 |
| step_i | input | 16 | Fractional step added per prescaler tick (limit 0x3333) |
| baud_tick | output | 1 | One-cycle baud enable pulse |

## Verification
A vector table tries several scale/step pairs, including the 115 kbaud setting, and compares long-run tick counts against the closed-form rate. This separates prescaler errors, which scale the count by (scale + 1), from accumulator-width or carry errors, which skew it by the step fraction.

Clamped steps (0x3334, 0xFFFF) and the zero step show whether the limit and the idle case are honoured. Directed first-tick timing at scale 0 and scale 0xFF pins down the exact cycle of the registered output.

A mid-run step change and an enable pause tell a proper restart apart from a stale phase, and a proper freeze apart from lost or extra ticks.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int SCALE_W_DEF  = 8;
  localparam int STEP_W_DEF   = 16;
  localparam int ACC_W_DEF    = 17;
  localparam int MAX_STEP_DEF = 32'h3333;

  // Saturate an unsigned value to an upper limit.
  function automatic int unsigned sat_to(input int unsigned v, input int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/bg_cfg_watch.sv
module bg_cfg_watch #(
  parameter int SCALE_W  = baud_gen_pkg::SCALE_W_DEF,
  parameter int STEP_W   = baud_gen_pkg::STEP_W_DEF,
  parameter int MAX_STEP = baud_gen_pkg::MAX_STEP_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [STEP_W-1:0]  step_i,
  output logic [SCALE_W-1:0] scale_o,
  output logic [STEP_W-1:0]  step_o,
  output logic               chg_o
);
  localparam int unsigned FULL_STEP = (1 << STEP_W) - 1;

  logic [SCALE_W-1:0] scale_q;
  logic [STEP_W-1:0]  raw_step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q    <= '0;
      raw_step_q <= '0;
    end else begin
      scale_q    <= scale_i;
      raw_step_q <= step_i;
    end
  end

  // A field differs from its held copy: restart the generator.
  assign chg_o   = (scale_i != scale_q) || (step_i != raw_step_q);
  assign scale_o = scale_q;

  generate
    if (MAX_STEP < FULL_STEP) begin : g_clamp
      assign step_o = STEP_W'(baud_gen_pkg::sat_to(32'(raw_step_q), MAX_STEP));
    end else begin : g_pass
      assign step_o = raw_step_q;
    end
  endgenerate

  // R5: the step handed on never exceeds the limit
  a_r5_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(step_o) <= MAX_STEP);
endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int SCALE_W = baud_gen_pkg::SCALE_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic [SCALE_W-1:0] limit_i,
  output logic               tick_o
);
  logic [SCALE_W-1:0] cnt_q;
  logic               at_top;

  assign at_top = (cnt_q == limit_i);
  assign tick_o = en_i && !clr_i && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (en_i)      cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end

  // R2: count never passes the limit
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_i);
  // R2: a tick is followed by a restart at zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
  // R8: a configuration change clears the count
  a_r8_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R9: disabled count holds
  a_r9_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bg_phase_acc.sv
module bg_phase_acc #(
  parameter int STEP_W = baud_gen_pkg::STEP_W_DEF,
  parameter int ACC_W  = baud_gen_pkg::ACC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              clr_i,
  input  logic [STEP_W-1:0] incr_i,
  output logic              tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             carry;
  logic             tick_q;

  function automatic logic [ACC_W:0] phase_add(input logic [ACC_W-1:0] a,
                                               input logic [STEP_W-1:0] s);
    return {1'b0, a} + (ACC_W+1)'(s);
  endfunction

  assign sum   = phase_add(acc_q, incr_i);
  assign carry = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= adv_i && carry;
      if (adv_i) acc_q <= sum[ACC_W-1:0];
    end
  end

  assign tick_o = tick_q;

  // R4: pulse lasts one cycle only
  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R4: every pulse follows an advance
  a_r4_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(adv_i));
  // R8: configuration change clears phase and output
  a_r8_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0 && !tick_o));
  // R9: phase holds without an advance
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/baud_phase_gen.sv
module baud_phase_gen #(
  parameter int SCALE_W  = baud_gen_pkg::SCALE_W_DEF,
  parameter int STEP_W   = baud_gen_pkg::STEP_W_DEF,
  parameter int ACC_W    = baud_gen_pkg::ACC_W_DEF,
  parameter int MAX_STEP = baud_gen_pkg::MAX_STEP_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [STEP_W-1:0]  step_i,
  output logic               baud_tick
);
  logic [SCALE_W-1:0] scale_held;
  logic [STEP_W-1:0]  step_held;
  logic               cfg_chg;
  logic               pre_tick;

  bg_cfg_watch #(.SCALE_W(SCALE_W), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .scale_i(scale_i), .step_i(step_i),
    .scale_o(scale_held), .step_o(step_held), .chg_o(cfg_chg)
  );

  bg_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en_i(en), .clr_i(cfg_chg),
    .limit_i(scale_held), .tick_o(pre_tick)
  );

  bg_phase_acc #(.STEP_W(STEP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv_i(pre_tick), .clr_i(cfg_chg),
    .incr_i(step_held), .tick_o(baud_tick)
  );

  // R9: no pulse after a disabled cycle
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !baud_tick);
  // R1: output low in the first cycle out of reset
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |=> !baud_tick);
endmodule

// File: tb/sim_baud_phase_gen.sv
`timescale 1ns/1ps
module sim_baud_phase_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0]  scale_i = '0;
  logic [15:0] step_i = '0;
  logic baud_tick;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  baud_phase_gen u0 (.clk(clk), .rst_n(rst_n), .en(en),
                     .scale_i(scale_i), .step_i(step_i), .baud_tick(baud_tick));

  // {scale, step, cycles}
  localparam logic [55:0] VEC [8] = '{
    {8'd0,   16'h3333, 32'd2000},
    {8'd0,   16'd603,  32'd20000},
    {8'd3,   16'h1000, 32'd4000},
    {8'd255, 16'h3333, 32'd30000},
    {8'd1,   16'hFFFF, 32'd3000},
    {8'd4,   16'h3334, 32'd5000},
    {8'd7,   16'h0000, 32'd2000},
    {8'd12,  16'h0ABC, 32'd8000}
  };

  function automatic longint model(input longint c, input longint s, input longint st);
    longint lim = (st > 32'h3333) ? 32'h3333 : st;
    longint pulses = c / (s + 1);
    return (pulses * lim) / 131072;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int dbl = 0;
  logic prev_tick = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_tick && baud_tick) dbl++;
    prev_tick <= baud_tick;
  end

  task automatic do_reset();
    @(negedge clk);
    en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_run(input int cycles, input bit enable, output int n);
    n = 0;
    en = enable;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
  endtask

  task automatic first_tick(input int limit, output int idx);
    idx = -1;
    en = 1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (baud_tick && idx < 0) idx = i;
    end
    en = 0;
  endtask

  initial begin
    int n, n2, nlow, idx;
    string tag;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 reset", baud_tick, 0);

    // Table: R3 with R5/R6/R7 corners
    foreach (VEC[v]) begin
      do_reset();
      scale_i = VEC[v][55:48];
      step_i  = VEC[v][47:32];
      repeat (3) @(negedge clk);
      count_run(int'(VEC[v][31:0]), 1'b1, n);
      en = 0;
      if (VEC[v][47:32] > 16'h3333)      tag = "R5 clamp";
      else if (VEC[v][55:48] == 8'hFF)  tag = "R6 max scale";
      else if (VEC[v][47:32] == 16'h0)  tag = "R7 zero step";
      else                              tag = "R3 rate";
      check(tag, n, model(longint'(VEC[v][31:0]), longint'(VEC[v][55:48]),
                          longint'(VEC[v][47:32])));
    end

    // R4: first tick timing at scale 0
    do_reset();
    scale_i = 8'd0; step_i = 16'h3333;
    repeat (3) @(negedge clk);
    first_tick(40, idx);
    check("R4 first tick", idx, 11);

    // R6: first tick timing at scale 0xFF
    do_reset();
    scale_i = 8'hFF; step_i = 16'h3333;
    repeat (3) @(negedge clk);
    first_tick(3000, idx);
    check("R6 first tick", idx, 2816);

    // R8: mid-run step change restarts
    do_reset();
    scale_i = 8'd0; step_i = 16'h3333;
    repeat (3) @(negedge clk);
    count_run(100, 1'b1, n);
    check("R8 before change", n, model(100, 0, 32'h3333));
    step_i = 16'h2000;
    count_run(500, 1'b1, n2);
    en = 0;
    check("R8 after change", n2, model(499, 0, 32'h2000));

    // R9: pause holds phase
    do_reset();
    scale_i = 8'd2; step_i = 16'h3333;
    repeat (3) @(negedge clk);
    count_run(301, 1'b1, n);
    count_run(200, 1'b0, nlow);
    check("R9 no ticks while disabled", nlow, 0);
    count_run(400, 1'b1, n2);
    en = 0;
    check("R9 resume total", n + n2, model(701, 2, 32'h3333));

    // R4: never two adjacent pulses
    check("R4 single-cycle pulse", dbl, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule